// File: doc/BRIEF.md
# Colour Cube Table Host Access Port

This block owns a colour lookup RAM holding a 17 x 17 x 17 cube of nodes. Each node stores three 12-bit components. A host CPU reaches the RAM through a small register bus, and the pixel pipeline reaches it through a separate registered read port. The host first raises the access-enable register, which takes the RAM away from the pixel path. It then writes a starting node index and a streaming direction into the address register, and moves nodes through a single data window. Finally it drops access-enable, which hands the RAM back to the pixel path.

Every node crosses the data window as two 32-bit words. The first word carries components 1 and 2. The second word carries component 0 and completes the node. On a write, the node reaches the RAM all at once when the second word arrives, never half-written. A node pointer advances after each completed node and wraps at the end of the cube. A control register also holds a table-enable bit and a 3-bit extend-enable field, which are passed on to the downstream datapath.

Top module: `lut3d_host_port`

## Requirements
- R1: After reset, the control, access-enable and address registers all read 0, the node pointer and word phase are 0, `bus_rdata` is 0 and `pix_node` is 0.
- R2: Register offset 0 is the control register. Bit 0 drives `lut_en`, bits 6:4 drive `ext_en`, and a read returns only those bits, with every other bit 0.
- R3: Offset 1 is the access-enable register, read back in bit 0. While it is 0, writes to the data window (offset 3) change neither the RAM, nor the pointer, nor the phase, and reads of the data window return 0.
- R4: Offset 2 is the address register. A write loads the node pointer from bits 12:0, or 0 if that value is above 4912, and sets the direction from bit 31 (0 = write streaming, 1 = read streaming). It also resets the word phase to the first word. A read returns the direction in bit 31 and the pointer in bits 12:0.
- R5: In write streaming, the first data-window write only latches component 1 (bits 27:16) and component 2 (bits 11:0). The RAM is left unchanged until the second word arrives.
- R6: The second data-window write takes component 0 from bits 11:0, commits all three components of the node at once, and advances the pointer by one.
- R7: In read streaming, the first data-window read returns component 1 in bits 27:16 and component 2 in bits 11:0. The second read returns component 0 in bits 11:0 and advances the pointer. Unused bits read 0.
- R8: The pointer wraps from node 4912 to node 0, so 9826 data-window accesses cover the whole cube and leave the pointer at 0.
- R9: Data-window writes during read streaming are ignored. Data-window reads during write streaming return 0 and leave the pointer and phase unchanged.
- R10: When access-enable is 0 and `pix_rd_en` is 1, `pix_node` shows the node at `pix_idx` one cycle later, packed as {c0, c1, c2}. While access-enable is 1, `pix_node` holds its value.
- R11: `bus_rdata` is registered. It changes only in the cycle after a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset: 0 control, 1 access-enable, 2 address, 3 data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lut_en | output | 1 | Table enable from the control register |
| ext_en | output | 3 | Extend-enable field from the control register |
| pix_rd_en | input | 1 | Pixel-path read request |
| pix_idx | input | 13 | Pixel-path node index |
| pix_node | output | 36 | Registered pixel-path node {c0, c1, c2} |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that `pix_idx` stays below 4913 whenever `pix_rd_en` is high. The bench issues exactly one bus operation per cycle, with an idle gap after each one. It fills the entire cube before any data-window or pixel read, so no uninitialised node is ever observed. Pixel indices come only from the valid range.

// File: rtl/lut3d_pkg.sv
package lut3d_pkg;
    typedef enum logic [1:0] {
        OFS_CTRL   = 2'd0,
        OFS_ACCESS = 2'd1,
        OFS_ADDR   = 2'd2,
        OFS_DATA   = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } word_phase_e;
endpackage

// File: rtl/lut3d_node_ram.sv
module lut3d_node_ram #(
    parameter int GRID = 17,
    parameter int CW   = 12
) (
    input  logic                                 clk,
    input  logic                                 we,
    input  logic [$clog2(GRID*GRID*GRID)-1:0]    host_addr,
    input  logic [3*CW-1:0]                      wnode,
    output logic [3*CW-1:0]                      host_rnode,
    input  logic [$clog2(GRID*GRID*GRID)-1:0]    pix_addr,
    output logic [3*CW-1:0]                      pix_rnode
);
    localparam int NODES = GRID * GRID * GRID;
    localparam int IW    = $clog2(NODES);
    localparam int NW    = 3 * CW;
    localparam logic [IW-1:0] LAST = IW'(NODES - 1);

    logic [NW-1:0] mem [NODES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[host_addr] <= wnode;
        end
    end

    always_comb begin
        host_rnode = mem[host_addr];
        pix_rnode  = (pix_addr <= LAST) ? mem[pix_addr] : '0;
    end
endmodule

// File: rtl/lut3d_pix_port.sv
module lut3d_pix_port #(
    parameter int CW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_on,
    input  logic            pix_rd_en,
    input  logic [3*CW-1:0] ram_node,
    output logic [3*CW-1:0] pix_node
);
    localparam int NW = 3 * CW;

    typedef struct packed {
        logic [NW-1:0] node;
    } pix_state_t;

    pix_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pix_rd_en && !host_on) begin
            s_d.node = ram_node;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pix_node = s_q.node;

    // R10
    pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_on |=> $stable(pix_node));
endmodule

// File: rtl/lut3d_host_regs.sv
module lut3d_host_regs
    import lut3d_pkg::*;
#(
    parameter int GRID = 17,
    parameter int CW   = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_wr,
    input  logic                                 bus_rd,
    input  logic [1:0]                           bus_addr,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          bus_rdata,
    output logic                                 lut_en,
    output logic [2:0]                           ext_en,
    output logic                                 host_on,
    output logic                                 ram_we,
    output logic [$clog2(GRID*GRID*GRID)-1:0]    ram_addr,
    output logic [3*CW-1:0]                      ram_wnode,
    input  logic [3*CW-1:0]                      ram_rnode
);
    localparam int NODES = GRID * GRID * GRID;
    localparam int IW    = $clog2(NODES);
    localparam logic [IW-1:0] LAST = IW'(NODES - 1);

    typedef struct packed {
        logic          lut_en;
        logic [2:0]    ext;
        logic          acc;
        logic          dir;
        word_phase_e   phase;
        logic [IW-1:0] ptr;
        logic [2*CW-1:0] hold;
        logic [31:0]   rdata;
    } host_state_t;

    host_state_t s_d, s_q;
    logic [IW-1:0] ptr_inc;
    logic [31:0]   rd_val;
    reg_ofs_e      ofs;

    always_comb begin
        ofs       = reg_ofs_e'(bus_addr);
        s_d       = s_q;
        ram_we    = 1'b0;
        ram_wnode = {bus_wdata[CW-1:0], s_q.hold};
        ptr_inc   = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        rd_val    = '0;

        if (bus_wr) begin
            case (ofs)
                OFS_CTRL: begin
                    s_d.lut_en = bus_wdata[0];
                    s_d.ext    = bus_wdata[6:4];
                end
                OFS_ACCESS: s_d.acc = bus_wdata[0];
                OFS_ADDR: begin
                    s_d.ptr   = (bus_wdata[IW-1:0] <= LAST) ? bus_wdata[IW-1:0] : '0;
                    s_d.dir   = bus_wdata[31];
                    s_d.phase = PH_FIRST;
                end
                OFS_DATA: begin
                    if (s_q.acc && !s_q.dir) begin
                        if (s_q.phase == PH_FIRST) begin
                            s_d.hold  = {bus_wdata[16 +: CW], bus_wdata[0 +: CW]};
                            s_d.phase = PH_SECOND;
                        end else begin
                            ram_we    = 1'b1;
                            s_d.ptr   = ptr_inc;
                            s_d.phase = PH_FIRST;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (bus_rd) begin
            case (ofs)
                OFS_CTRL: begin
                    rd_val[0]   = s_q.lut_en;
                    rd_val[6:4] = s_q.ext;
                end
                OFS_ACCESS: rd_val[0] = s_q.acc;
                OFS_ADDR: begin
                    rd_val[31]     = s_q.dir;
                    rd_val[IW-1:0] = s_q.ptr;
                end
                OFS_DATA: begin
                    if (s_q.acc && s_q.dir) begin
                        if (s_q.phase == PH_FIRST) begin
                            rd_val[16 +: CW] = ram_rnode[CW +: CW];
                            rd_val[0 +: CW]  = ram_rnode[0 +: CW];
                            s_d.phase        = PH_SECOND;
                        end else begin
                            rd_val[0 +: CW]  = ram_rnode[2*CW +: CW];
                            s_d.ptr          = ptr_inc;
                            s_d.phase        = PH_FIRST;
                        end
                    end
                end
                default: ;
            endcase
            s_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign lut_en    = s_q.lut_en;
    assign ext_en    = s_q.ext;
    assign host_on   = s_q.acc;
    assign ram_addr  = s_q.ptr;

    // bus protocol: one operation per cycle
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R3
    no_access_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.acc && bus_wr && bus_addr == OFS_DATA) |=> $stable(s_q.ptr) && $stable(s_q.phase));

    // R4
    addr_phase_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ADDR) |=> (s_q.phase == PH_FIRST));

    // R5
    first_word_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_FIRST) |-> !ram_we);

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && s_q.ptr == LAST) |=> (s_q.ptr == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/lut3d_host_port.sv
module lut3d_host_port #(
    parameter int GRID = 17,
    parameter int CW   = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_wr,
    input  logic                                 bus_rd,
    input  logic [1:0]                           bus_addr,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          bus_rdata,
    output logic                                 lut_en,
    output logic [2:0]                           ext_en,
    input  logic                                 pix_rd_en,
    input  logic [$clog2(GRID*GRID*GRID)-1:0]    pix_idx,
    output logic [3*CW-1:0]                      pix_node
);
    localparam int NODES = GRID * GRID * GRID;
    localparam int IW    = $clog2(NODES);
    localparam int NW    = 3 * CW;

    logic          host_on;
    logic          ram_we;
    logic [IW-1:0] ram_addr;
    logic [NW-1:0] ram_wnode;
    logic [NW-1:0] host_rnode;
    logic [NW-1:0] pix_rnode;

    lut3d_host_regs #(.GRID(GRID), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lut_en    (lut_en),
        .ext_en    (ext_en),
        .host_on   (host_on),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wnode (ram_wnode),
        .ram_rnode (host_rnode)
    );

    lut3d_node_ram #(.GRID(GRID), .CW(CW)) u_ram (
        .clk        (clk),
        .we         (ram_we),
        .host_addr  (ram_addr),
        .wnode      (ram_wnode),
        .host_rnode (host_rnode),
        .pix_addr   (pix_idx),
        .pix_rnode  (pix_rnode)
    );

    lut3d_pix_port #(.CW(CW)) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_on   (host_on),
        .pix_rd_en (pix_rd_en),
        .ram_node  (pix_rnode),
        .pix_node  (pix_node)
    );

    // R3: host writes never reach the RAM while the pixel path owns it
    ram_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> host_on);
endmodule

// File: tb/lut3d_host_port_bench.sv
module lut3d_host_port_bench;
    localparam int N = 4913;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lut_en;
    logic [2:0]  ext_en;
    logic        pix_rd_en = 1'b0;
    logic [12:0] pix_idx = '0;
    logic [35:0] pix_node;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string cur_req = "R1";

    // reference model
    logic [35:0] m_mem [N];
    int          m_ptr, m_ph, m_dir, m_acc, m_en, m_ext;
    logic [23:0] m_hold;
    logic [31:0] m_rdata;
    logic [35:0] m_pix;

    lut3d_host_port u_lut3d_host_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lut_en(lut_en), .ext_en(ext_en), .pix_rd_en(pix_rd_en),
        .pix_idx(pix_idx), .pix_node(pix_node)
    );

    always #10 clk = ~clk;

    function automatic logic [35:0] pattern(int i);
        logic [11:0] a, b, c;
        a = 12'((i * 3) & 'hfff);
        b = 12'((i * 7 + 5) & 'hfff);
        c = 12'((i ^ 'ha5a) & 'hfff);
        return {a, b, c};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_ph = 0; m_dir = 0; m_acc = 0; m_en = 0; m_ext = 0;
            m_hold = '0; m_rdata = '0; m_pix = '0;
        end else begin
            if (pix_rd_en && m_acc == 0) m_pix = m_mem[pix_idx];
            if (bus_rd) begin
                m_rdata = '0;
                if (bus_addr == 0) m_rdata = 32'(m_en) | (32'(m_ext) << 4);
                else if (bus_addr == 1) m_rdata = 32'(m_acc);
                else if (bus_addr == 2) m_rdata = (32'(m_dir) << 31) | 32'(m_ptr);
                else if (m_acc == 1 && m_dir == 1) begin
                    if (m_ph == 0) begin
                        m_rdata = {4'h0, m_mem[m_ptr][23:12], 4'h0, m_mem[m_ptr][11:0]};
                        m_ph = 1;
                    end else begin
                        m_rdata = {20'h0, m_mem[m_ptr][35:24]};
                        m_ph = 0;
                        m_ptr = (m_ptr + 1) % N;
                    end
                end
            end
            if (bus_wr) begin
                if (bus_addr == 0) begin m_en = int'(bus_wdata[0]); m_ext = int'(bus_wdata[6:4]); end
                else if (bus_addr == 1) m_acc = int'(bus_wdata[0]);
                else if (bus_addr == 2) begin
                    m_ptr = (int'(bus_wdata[12:0]) < N) ? int'(bus_wdata[12:0]) : 0;
                    m_dir = int'(bus_wdata[31]);
                    m_ph = 0;
                end else if (m_acc == 1 && m_dir == 0) begin
                    if (m_ph == 0) begin
                        m_hold = {bus_wdata[27:16], bus_wdata[11:0]};
                        m_ph = 1;
                    end else begin
                        m_mem[m_ptr] = {bus_wdata[11:0], m_hold};
                        m_ph = 0;
                        m_ptr = (m_ptr + 1) % N;
                    end
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (bus_rdata !== m_rdata || pix_node !== m_pix ||
                lut_en !== m_en[0] || ext_en !== m_ext[2:0]) begin
                errors++;
                $display("FAIL %s: rdata=%h pix=%h en=%b ext=%h expected rdata=%h pix=%h en=%b ext=%h",
                         cur_req, bus_rdata, pix_node, lut_en, ext_en,
                         m_rdata, m_pix, m_en[0], m_ext[2:0]);
            end
        end
    end

    task automatic op(input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        op(1, 0, a, d);
    endtask

    task automatic rreg(input logic [1:0] a);
        op(0, 1, a, '0);
    endtask

    task automatic put_node(input logic [35:0] n);
        wreg(2'd3, {4'h0, n[23:12], 4'h0, n[11:0]});
        wreg(2'd3, {20'h0, n[35:24]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        rreg(0); rreg(1); rreg(2); rreg(3);

        cur_req = "R2";
        wreg(0, 32'hffff_ffff); rreg(0);
        wreg(0, 32'h0000_0010); rreg(0);

        cur_req = "R6";
        wreg(1, 1);
        wreg(2, 0);
        for (int i = 0; i < N; i++) put_node(pattern(i));
        cur_req = "R8";
        rreg(2);

        cur_req = "R7";
        wreg(2, 32'h8000_0000);
        for (int i = 0; i < N; i++) begin rreg(3); rreg(3); end
        cur_req = "R8";
        rreg(2);
        wreg(2, 32'h8000_0000 | 4912); rreg(3); rreg(3); rreg(2);

        cur_req = "R4";
        wreg(2, 32'h8000_0000 | 5000); rreg(2);
        wreg(2, 32'h8000_0000 | 40); rreg(3); wreg(2, 32'h8000_0000 | 40); rreg(3); rreg(3);

        cur_req = "R5";
        wreg(2, 7); wreg(3, 32'h0abc_0def);
        wreg(2, 32'h8000_0007); rreg(3); rreg(3);
        wreg(2, 9); put_node(36'h123_456_789);
        wreg(2, 32'h8000_0009); rreg(3); rreg(3); rreg(2);

        cur_req = "R9";
        wreg(2, 32'h8000_0011); wreg(3, 32'h0fff_0fff); wreg(3, 32'hfff);
        rreg(2); rreg(3); rreg(3);
        wreg(2, 12); rreg(3); rreg(3); rreg(2);

        cur_req = "R3";
        wreg(2, 5); wreg(1, 0); rreg(1);
        put_node(36'hfff_fff_fff); rreg(3); rreg(2);
        wreg(1, 1); wreg(2, 32'h8000_0005); rreg(3); rreg(3);

        cur_req = "R10";
        wreg(1, 0);
        foreach (pix_idx[k]) begin
            pix_rd_en = 1; pix_idx = 13'(1 << k);
            @(negedge clk);
        end
        pix_idx = 13'd4912; @(negedge clk);
        pix_idx = 13'd9; @(negedge clk);
        pix_rd_en = 0; pix_idx = 13'd3; @(negedge clk);
        wreg(1, 1);
        pix_rd_en = 1; pix_idx = 13'd100; @(negedge clk); @(negedge clk);
        pix_rd_en = 0;

        cur_req = "R11";
        rreg(0); @(negedge clk); @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule